// File: doc/BRIEF.md
# Half-Precision Classify and Compare Unit

This unit performs the non-arithmetic operations on IEEE 754 binary16 values stored in 64-bit floating-point register images: it classifies a value into one of ten classes, compares two values for equality or ordering, and selects the smaller or larger of two values. Each register image is first checked for a proper boxing pattern. A register whose upper 48 bits are not all ones is read as the canonical half-precision NaN.

A request is presented as one cycle of `in_valid` with two operands, a 7-bit function code and a 3-bit sub-function. One clock later the unit raises `out_valid` for one cycle. At the same time it presents the 64-bit result, a flag telling whether that result is an integer or a floating-point register image, and an invalid-operation flag. Requests may arrive on every cycle.

The output side is a two-state machine. `ST_IDLE` means no result is being presented. `ST_SHOW` means a fresh result is on the outputs. A strobe moves the machine to `ST_SHOW`, or keeps it there. A cycle without a strobe returns it to `ST_IDLE`. In `ST_IDLE` the result and flags keep their last values.

Top module: `hcmp_unit`

## Requirements
- R1: An operand is the low 16 bits of its register only when register bits 63:16 are all ones. Otherwise the operand is the canonical NaN 0x7E00, which is a quiet NaN.
- R2: Classify (function 0x16 is not it; function 0x72, sub-function 1) produces a mask with this bit order: 0 negative infinity, 1 negative normal, 2 negative subnormal, 3 negative zero, 4 positive zero, 5 positive subnormal, 6 positive normal, 7 positive infinity, 8 signaling NaN (exponent 0x1F, fraction MSB 0, fraction nonzero), 9 quiet NaN (exponent 0x1F, fraction MSB 1).
- R3: A classify result has exactly one of bits 9:0 set, bits 63:10 zero, `result_is_int` = 1 and `invalid` = 0.
- R4: Equal (function 0x52, sub-function 2) returns 1 when neither operand is NaN and the two values are numerically equal (+0 equals -0), and returns 0 otherwise. `invalid` is set only if an operand is a signaling NaN.
- R5: Less-than (0x52 sub-function 1) and less-or-equal (0x52 sub-function 0) return the numeric ordering as 0 or 1, with +0 and -0 equal. If any operand is NaN they return 0 and set `invalid`. All compare results have `result_is_int` = 1.
- R6: Min (0x16 sub-function 0) returns the numerically smaller value, and returns -0 when the operands are +0 and -0 in either order.
- R7: Max (0x16 sub-function 1) returns the numerically larger value, and returns +0 when the operands are +0 and -0 in either order.
- R8: For min and max, when exactly one operand is NaN the other one is returned, and when both are NaN the result is 0x7E00. `invalid` is set only if an operand is a signaling NaN. Results are boxed with bits 63:16 all ones and have `result_is_int` = 0.
- R9: Any other pair of function code and sub-function yields a zero result, with `result_is_int` = 0 and `invalid` = 0.
- R10: Result and flags appear one clock after a cycle with `in_valid`, together with a one-cycle `out_valid`. Cycles without a strobe leave the result and flags unchanged.
- R11: While `rst_n` is low, `out_valid`, `result`, `result_is_int` and `invalid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| opa | input | 64 | First operand register image |
| opb | input | 64 | Second operand register image |
| func | input | 7 | Function code |
| subfn | input | 3 | Sub-function field |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| result | output | 64 | Integer result or boxed half-precision value |
| result_is_int | output | 1 | 1 when `result` is an integer |
| invalid | output | 1 | Invalid-operation flag |

## Verification
The unit holds no state other than the presentation register, so an internal fault shows at the ports on the very next `out_valid` cycle. The fault appears as a wrong class bit, a wrong compare bit, the wrong operand chosen, or a missing or stuck `out_valid`. Signed-zero and NaN ordering faults are visible only for specific operand pairs. For that reason the bench sweeps every binary16 encoding through classify, and every pair from a set of boundary values through each compare and select operation.

// File: rtl/hcmp_pkg.sv
`timescale 1ns/1ps
package hcmp_pkg;

    // operation selected by the decoder
    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_CLASS = 3'd1,
        K_EQ    = 3'd2,
        K_LT    = 3'd3,
        K_LE    = 3'd4,
        K_MIN   = 3'd5,
        K_MAX   = 3'd6
    } op_kind_e;

    // function codes the decoder recognises
    localparam logic [6:0] FN_SELECT = 7'h16;
    localparam logic [6:0] FN_ORDER  = 7'h52;
    localparam logic [6:0] FN_CLASS  = 7'h72;

    // number of classes in the classify mask
    localparam int unsigned CLASS_N = 10;

    // decoded properties of one half-precision operand
    typedef struct packed {
        logic sign;
        logic is_zero;
        logic is_sub;
        logic is_norm;
        logic is_inf;
        logic is_snan;
        logic is_qnan;
    } hinfo_t;

    // output presentation state
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SHOW = 1'b1
    } show_state_e;

endpackage

// File: rtl/hcmp_decode.sv
`timescale 1ns/1ps
module hcmp_decode
    import hcmp_pkg::*;
(
    input  logic [6:0] func,
    input  logic [2:0] subfn,
    output op_kind_e   kind
);

    always_comb begin
        kind = K_NONE;
        unique case (func)
            FN_SELECT: begin
                if (subfn == 3'd0)      kind = K_MIN;
                else if (subfn == 3'd1) kind = K_MAX;
            end
            FN_ORDER: begin
                if (subfn == 3'd0)      kind = K_LE;
                else if (subfn == 3'd1) kind = K_LT;
                else if (subfn == 3'd2) kind = K_EQ;
            end
            FN_CLASS: begin
                if (subfn == 3'd1)      kind = K_CLASS;
            end
            default: kind = K_NONE;
        endcase
    end

endmodule

// File: rtl/hcmp_unbox.sv
`timescale 1ns/1ps
module hcmp_unbox
    import hcmp_pkg::*;
#(
    parameter int unsigned REG_W  = 64,
    parameter int unsigned EXP_W  = 5,
    parameter int unsigned FRAC_W = 10,
    localparam int unsigned HW    = 1 + EXP_W + FRAC_W
) (
    input  logic [REG_W-1:0] reg_in,
    output logic [HW-1:0]    half,
    output hinfo_t           info
);

    localparam logic [HW-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic              boxed;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic              exp_max;
    logic              exp_min;
    logic              frac_nz;

    always_comb begin
        boxed   = &reg_in[REG_W-1:HW];
        half    = boxed ? reg_in[HW-1:0] : CANON_NAN;
        expo    = half[HW-2:FRAC_W];
        frac    = half[FRAC_W-1:0];
        exp_max = &expo;
        exp_min = ~|expo;
        frac_nz = |frac;

        info.sign    = half[HW-1];
        info.is_zero = exp_min && !frac_nz;
        info.is_sub  = exp_min && frac_nz;
        info.is_norm = !exp_min && !exp_max;
        info.is_inf  = exp_max && !frac_nz;
        info.is_snan = exp_max && frac_nz && !frac[FRAC_W-1];
        info.is_qnan = exp_max && frac[FRAC_W-1];
    end

endmodule

// File: rtl/hcmp_classify.sv
`timescale 1ns/1ps
module hcmp_classify
    import hcmp_pkg::*;
(
    input  hinfo_t             info,
    output logic [CLASS_N-1:0] mask
);

    always_comb begin
        mask    = '0;
        mask[0] =  info.sign && info.is_inf;
        mask[1] =  info.sign && info.is_norm;
        mask[2] =  info.sign && info.is_sub;
        mask[3] =  info.sign && info.is_zero;
        mask[4] = !info.sign && info.is_zero;
        mask[5] = !info.sign && info.is_sub;
        mask[6] = !info.sign && info.is_norm;
        mask[7] = !info.sign && info.is_inf;
        mask[8] =  info.is_snan;
        mask[9] =  info.is_qnan;
    end

endmodule

// File: rtl/hcmp_order.sv
`timescale 1ns/1ps
module hcmp_order
    import hcmp_pkg::*;
#(
    parameter int unsigned REG_W  = 64,
    parameter int unsigned EXP_W  = 5,
    parameter int unsigned FRAC_W = 10,
    localparam int unsigned HW    = 1 + EXP_W + FRAC_W
) (
    input  op_kind_e         kind,
    input  logic [HW-1:0]    a_half,
    input  logic [HW-1:0]    b_half,
    input  hinfo_t           a_info,
    input  hinfo_t           b_info,
    output logic [REG_W-1:0] value,
    output logic             value_is_int,
    output logic             inval
);

    localparam logic [HW-1:0] CANON_NAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};
    localparam logic [REG_W-HW-1:0] BOX_ONES = '1;

    logic            a_nan, b_nan, any_nan, any_snan;
    logic            same_num;
    logic            a_lt_b, b_lt_a, eq_ord;
    logic            min_pick_a, max_pick_a;
    logic [HW-1:0]   sel_half;

    // strict ordering of two non-NaN values given as sign-magnitude
    function automatic logic mag_less(input logic [HW-1:0] x,
                                      input logic [HW-1:0] y);
        logic [HW-2:0] mx, my;
        mx = x[HW-2:0];
        my = y[HW-2:0];
        if (x[HW-1] != y[HW-1]) return x[HW-1];
        if (x[HW-1])            return mx > my;
        return mx < my;
    endfunction

    always_comb begin
        a_nan    = a_info.is_snan || a_info.is_qnan;
        b_nan    = b_info.is_snan || b_info.is_qnan;
        any_nan  = a_nan || b_nan;
        any_snan = a_info.is_snan || b_info.is_snan;
        same_num = (a_half == b_half) || (a_info.is_zero && b_info.is_zero);
        eq_ord   = !any_nan && same_num;
        a_lt_b   = !any_nan && !same_num && mag_less(a_half, b_half);
        b_lt_a   = !any_nan && !same_num && mag_less(b_half, a_half);

        min_pick_a = a_lt_b || (eq_ord && a_info.sign) || b_nan;
        max_pick_a = b_lt_a || (eq_ord && b_info.sign) || b_nan;

        sel_half = '0;
        if (kind == K_MIN) sel_half = min_pick_a ? a_half : b_half;
        if (kind == K_MAX) sel_half = max_pick_a ? a_half : b_half;
        if (a_nan && b_nan) sel_half = CANON_NAN;

        value        = '0;
        value_is_int = 1'b0;
        inval        = 1'b0;
        unique case (kind)
            K_EQ: begin
                value[0]     = eq_ord;
                value_is_int = 1'b1;
                inval        = any_snan;
            end
            K_LT: begin
                value[0]     = a_lt_b;
                value_is_int = 1'b1;
                inval        = any_nan;
            end
            K_LE: begin
                value[0]     = a_lt_b || eq_ord;
                value_is_int = 1'b1;
                inval        = any_nan;
            end
            K_MIN, K_MAX: begin
                value = {BOX_ONES, sel_half};
                inval = any_snan;
            end
            default: begin
                value        = '0;
                value_is_int = 1'b0;
                inval        = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hcmp_unit.sv
`timescale 1ns/1ps
module hcmp_unit
    import hcmp_pkg::*;
#(
    parameter int unsigned REG_W  = 64,
    parameter int unsigned EXP_W  = 5,
    parameter int unsigned FRAC_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [REG_W-1:0] opa,
    input  logic [REG_W-1:0] opb,
    input  logic [6:0]       func,
    input  logic [2:0]       subfn,
    output logic             out_valid,
    output logic [REG_W-1:0] result,
    output logic             result_is_int,
    output logic             invalid
);

    localparam int unsigned HW    = 1 + EXP_W + FRAC_W;
    localparam int unsigned OPS_N = 2;

    logic [REG_W-1:0] reg_vec  [OPS_N];
    logic [HW-1:0]    half_vec [OPS_N];
    hinfo_t           info_vec [OPS_N];

    op_kind_e           kind;
    logic [CLASS_N-1:0] class_mask;
    logic [REG_W-1:0]   ord_value;
    logic               ord_is_int;
    logic               ord_inval;

    logic [REG_W-1:0]   next_result;
    logic               next_is_int;
    logic               next_inval;

    show_state_e        state_q, state_d;
    op_kind_e           kind_q;

    assign reg_vec[0] = opa;
    assign reg_vec[1] = opb;

    for (genvar g = 0; g < OPS_N; g++) begin : g_unbox
        hcmp_unbox #(
            .REG_W (REG_W),
            .EXP_W (EXP_W),
            .FRAC_W(FRAC_W)
        ) unbox_i (
            .reg_in(reg_vec[g]),
            .half  (half_vec[g]),
            .info  (info_vec[g])
        );
    end

    hcmp_decode decode_i (
        .func (func),
        .subfn(subfn),
        .kind (kind)
    );

    hcmp_classify classify_i (
        .info(info_vec[0]),
        .mask(class_mask)
    );

    hcmp_order #(
        .REG_W (REG_W),
        .EXP_W (EXP_W),
        .FRAC_W(FRAC_W)
    ) order_i (
        .kind        (kind),
        .a_half      (half_vec[0]),
        .b_half      (half_vec[1]),
        .a_info      (info_vec[0]),
        .b_info      (info_vec[1]),
        .value       (ord_value),
        .value_is_int(ord_is_int),
        .inval       (ord_inval)
    );

    // result selection between classify and the ordering datapath
    always_comb begin
        if (kind == K_CLASS) begin
            next_result = {{(REG_W-CLASS_N){1'b0}}, class_mask};
            next_is_int = 1'b1;
            next_inval  = 1'b0;
        end else begin
            next_result = ord_value;
            next_is_int = ord_is_int;
            next_inval  = ord_inval;
        end
    end

    // next-state logic of the presentation machine
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = in_valid ? ST_SHOW : ST_IDLE;
            ST_SHOW: state_d = in_valid ? ST_SHOW : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register: loads on a strobe, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result        <= '0;
            result_is_int <= 1'b0;
            invalid       <= 1'b0;
            kind_q        <= K_NONE;
        end else if (in_valid) begin
            result        <= next_result;
            result_is_int <= next_is_int;
            invalid       <= next_inval;
            kind_q        <= kind;
        end
    end

    assign out_valid = (state_q == ST_SHOW);

    AST_STROBE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(invalid) && $stable(result_is_int))); // R10
    AST_CLASS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && kind_q == K_CLASS) |->
            ($countones(result[CLASS_N-1:0]) == 1 && result[REG_W-1:CLASS_N] == '0
             && result_is_int && !invalid)); // R3
    AST_CMP_BOOL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (kind_q == K_EQ || kind_q == K_LT || kind_q == K_LE)) |->
            (result[REG_W-1:1] == '0 && result_is_int)); // R5
    AST_SEL_BOXED: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (kind_q == K_MIN || kind_q == K_MAX)) |->
            (&result[REG_W-1:HW] && !result_is_int)); // R8
    AST_UNKNOWN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && kind_q == K_NONE) |->
            (result == '0 && !result_is_int && !invalid)); // R9

endmodule

// File: tb/hcmp_unit_tb_top.sv
`timescale 1ns/1ps
module hcmp_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic [6:0]  func = '0;
    logic [2:0]  subfn = '0;
    logic        out_valid;
    logic [63:0] result;
    logic        result_is_int;
    logic        invalid;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam logic [47:0] ONES = 48'hFFFF_FFFF_FFFF;

    always #5 clk = ~clk;

    hcmp_unit dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opa(opa), .opb(opb), .func(func), .subfn(subfn),
        .out_valid(out_valid), .result(result),
        .result_is_int(result_is_int), .invalid(invalid)
    );

    function automatic bit is_nan(input logic [15:0] h);
        return (h[14:10] == 5'h1F) && (h[9:0] != 0);
    endfunction

    function automatic bit is_snan(input logic [15:0] h);
        return is_nan(h) && !h[9];
    endfunction

    // numeric value of a non-NaN half
    function automatic real h2r(input logic [15:0] h);
        real r;
        int  e;
        e = h[14:10];
        if (e == 31) r = 1.0e9;
        else begin
            r = (e == 0) ? real'(h[9:0]) : real'(h[9:0]) + 1024.0;
            for (int k = 1; k < ((e == 0) ? 1 : e); k++) r = r * 2.0;
            r = r / 16777216.0;
        end
        return h[15] ? -r : r;
    endfunction

    function automatic logic [9:0] exp_class(input logic [15:0] h);
        logic [9:0] m;
        int e;
        m = '0;
        e = h[14:10];
        if (is_nan(h))        m[h[9] ? 9 : 8] = 1'b1;
        else if (e == 31)     m[h[15] ? 0 : 7] = 1'b1;
        else if (e == 0 && h[9:0] == 0) m[h[15] ? 3 : 4] = 1'b1;
        else if (e == 0)      m[h[15] ? 2 : 5] = 1'b1;
        else                  m[h[15] ? 1 : 6] = 1'b1;
        return m;
    endfunction

    task automatic issue(input logic [63:0] a, input logic [63:0] b,
                         input logic [6:0] f, input logic [2:0] s);
        @(negedge clk);
        opa = a; opb = b; func = f; subfn = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check(input string req, input logic [63:0] er,
                         input bit eint, input bit einv);
        n_run++;
        if (out_valid !== 1'b1 || result !== er || result_is_int !== eint
            || invalid !== einv) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h f=%h s=%0d: got v=%b r=%h i=%b x=%b exp v=1 r=%h i=%b x=%b",
                     req, opa, opb, func, subfn, out_valid, result, result_is_int,
                     invalid, er, eint, einv);
        end
    endtask

    logic [15:0] vals [22] = '{
        16'h0000, 16'h8000, 16'h0001, 16'h8001, 16'h03FF, 16'h0400,
        16'h3C00, 16'hBC00, 16'h3C01, 16'h4000, 16'hC000, 16'h7BFF,
        16'hFBFF, 16'h7C00, 16'hFC00, 16'h7E00, 16'hFE00, 16'h7C01,
        16'h7D00, 16'hFD00, 16'h3555, 16'hB555 };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        n_run++;
        if (out_valid !== 0 || result !== 0 || result_is_int !== 0 || invalid !== 0) begin
            n_fail++;
            $display("FAIL R11 reset v=%b r=%h i=%b x=%b exp all zero",
                     out_valid, result, result_is_int, invalid);
        end
        @(negedge clk) rst_n = 1'b1;

        // R2 R3: every binary16 encoding through classify
        for (int i = 0; i < 65536; i++) begin
            issue({ONES, 16'(i)}, '0, 7'h72, 3'd1);
            check("R2", {54'd0, exp_class(16'(i))}, 1'b1, 1'b0);
        end

        // R1: badly boxed registers read as quiet NaN
        issue(64'h0000_0000_0000_3C00, '0, 7'h72, 3'd1);
        check("R1", 64'h200, 1'b1, 1'b0);
        issue(64'h7FFF_FFFF_FFFF_0000, '0, 7'h72, 3'd1);
        check("R1", 64'h200, 1'b1, 1'b0);
        issue(64'h0000_0000_0000_3C00, {ONES, 16'h4000}, 7'h16, 3'd0);
        check("R1", {ONES, 16'h4000}, 1'b0, 1'b0);
        issue({ONES, 16'h3C00}, 64'h1234_0000_0000_3C00, 7'h52, 3'd2);
        check("R1", 64'd0, 1'b1, 1'b0);

        // R4 R5 R6 R7 R8: all pairs of boundary values
        for (int i = 0; i < 22; i++) begin
            for (int j = 0; j < 22; j++) begin
                logic [15:0] a, b, mn, mx;
                bit an, bn, sn, lt, eq;
                a = vals[i]; b = vals[j];
                an = is_nan(a); bn = is_nan(b);
                sn = is_snan(a) || is_snan(b);
                lt = !an && !bn && (h2r(a) < h2r(b));
                eq = !an && !bn && (h2r(a) == h2r(b));
                if (an && bn)           begin mn = 16'h7E00; mx = 16'h7E00; end
                else if (an)            begin mn = b; mx = b; end
                else if (bn)            begin mn = a; mx = a; end
                else if (h2r(a) < h2r(b)) begin mn = a; mx = b; end
                else if (h2r(b) < h2r(a)) begin mn = b; mx = a; end
                else begin
                    mn = a[15] ? a : b;
                    mx = a[15] ? b : a;
                end
                issue({ONES, a}, {ONES, b}, 7'h52, 3'd2);
                check("R4", {63'd0, eq}, 1'b1, sn);
                issue({ONES, a}, {ONES, b}, 7'h52, 3'd1);
                check("R5", {63'd0, lt}, 1'b1, an || bn);
                issue({ONES, a}, {ONES, b}, 7'h52, 3'd0);
                check("R5", {63'd0, lt || eq}, 1'b1, an || bn);
                issue({ONES, a}, {ONES, b}, 7'h16, 3'd0);
                check((an || bn) ? "R8" : "R6", {ONES, mn}, 1'b0, sn);
                issue({ONES, a}, {ONES, b}, 7'h16, 3'd1);
                check((an || bn) ? "R8" : "R7", {ONES, mx}, 1'b0, sn);
            end
        end

        // R9: unrecognised codes
        issue({ONES, 16'h3C00}, {ONES, 16'h7C01}, 7'h72, 3'd0);
        check("R9", 64'd0, 1'b0, 1'b0);
        issue({ONES, 16'h3C00}, {ONES, 16'h7C01}, 7'h52, 3'd3);
        check("R9", 64'd0, 1'b0, 1'b0);
        issue({ONES, 16'h3C00}, {ONES, 16'h7C01}, 7'h16, 3'd2);
        check("R9", 64'd0, 1'b0, 1'b0);
        issue({ONES, 16'h3C00}, {ONES, 16'h7C01}, 7'h10, 3'd0);
        check("R9", 64'd0, 1'b0, 1'b0);

        // R10: after a strobe, idle cycles drop out_valid and hold the outputs
        issue({ONES, 16'h7C01}, {ONES, 16'h3C00}, 7'h16, 3'd1);
        check("R10", {ONES, 16'h3C00}, 1'b0, 1'b1);
        opa = '0; opb = '0; func = 7'h52; subfn = 3'd1;
        repeat (2) @(negedge clk);
        n_run++;
        if (out_valid !== 0 || result !== {ONES, 16'h3C00} || result_is_int !== 0
            || invalid !== 1) begin
            n_fail++;
            $display("FAIL R10 hold v=%b r=%h i=%b x=%b exp v=0 r=%h i=0 x=1",
                     out_valid, result, result_is_int, invalid, {ONES, 16'h3C00});
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule